// File: doc/BRIEF.md
# System Clock Divider with Low-Power Wake-Up Exit

This block holds the system clock control byte of a small microcontroller and turns it into a clock-enable pulse for the rest of the core. A two-bit code picks a divide ratio of 1, 2, 4 or 8. A low-power bit overrides the code and slows the enable to one pulse every 256 cycles. The stored code is kept untouched while low-power mode is on, so it comes back into force when low-power mode ends.

A group of wake-up event inputs can end low-power mode on their own, provided the wake-exit enable bit is set. A halt request bit suppresses the clock enable until an external wake input clears it. The oscillator choice is modelled only as a select bit and a crystal-ready input. A read-only status bit reports that the ring oscillator is in use, either because it is selected or because the crystal is not yet ready. When the ratio changes, the counter finishes the current interval first, so no enable interval is ever cut short.

Top module: `sysclk_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x60: oscillator select (bit 6) is 1, status (bit 5) is 1, and the halt (bit 4), wake-exit enable (bit 3), low-power (bit 2) and divide code (bits 1:0) fields are 0. Bit 7 always reads 0, whatever is written to it.
- R2: Status bit 5 and `ring_sel_o` equal oscillator-select OR NOT `xtal_ready`. Bit 5 cannot be written.
- R3: With low-power off, divide codes 00, 01, 10 and 11 make `clk_en` a one-cycle pulse every 1, 2, 4 and 8 cycles.
- R4: With low-power bit 2 set, `clk_en` pulses once every 256 cycles, whatever the divide code is.
- R5: While low-power bit 2 is 1, writes to bits 1:0 are ignored, and the stored code reads back unchanged.
- R6: When low-power and wake-exit enable (bit 3) are both 1 and any `wake_evt` bit is 1, low-power clears on the next edge. The divide code is kept. When wake-exit enable is 0, wake events leave low-power set.
- R7: While low-power is 1 and any `wake_evt` bit is asserted, a write that sets bit 3 leaves bit 3 unchanged. The same write succeeds once no event is asserted.
- R8: Writing 1 to bit 4 raises `stop_o` and leaves the divide code unchanged. An asserted `ext_wake` clears bit 4 on the next edge.
- R9: While `stop_o` is 1, `clk_en` stays 0.
- R10: A change of ratio, including the one caused by a wake-up exit, takes effect only after the current enable interval completes. The interval in progress keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data for the control byte |
| rd_data | output | 8 | Current control byte including the status bit |
| xtal_ready | input | 1 | High-frequency source has finished warming up |
| wake_evt | input | 9 | Wake-up event lines, one per source, any bit counts |
| ext_wake | input | 1 | External wake input that clears the halt request |
| ring_sel_o | output | 1 | Ring oscillator is the active source |
| stop_o | output | 1 | Halt request to the power controller |
| clk_en | output | 1 | One-cycle clock-enable pulse at the chosen rate |

## Verification
The divider is measured as the gap between consecutive `clk_en` pulses. It is measured under each of the four codes, under low-power with a nonzero code, and after a wake-up exit, so that a wrong ratio shows up as a wrong gap. Wake events are applied with the wake-exit enable both off and on, and while a write to bit 3 is in flight. This separates the automatic exit from the write-blocking rule. One ratio change is made in the middle of an interval, from divide-by-8 down to divide-by-1. The wake-up exit also lands in the middle of a 256-cycle interval. Both cases show whether the interval in progress is cut short.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;

    localparam int REG_W   = 8;
    localparam int CODE_W  = 2;
    localparam int SHIFT_W = 4;

    localparam int BIT_RSV  = 7;
    localparam int BIT_OSC  = 6;
    localparam int BIT_STAT = 5;
    localparam int BIT_HALT = 4;
    localparam int BIT_WEN  = 3;
    localparam int BIT_LP   = 2;

    typedef struct packed {
        logic              osc_sel;
        logic              halt;
        logic              wake_en;
        logic              lp_en;
        logic [CODE_W-1:0] div_code;
    } ctl_reg_t;

    typedef logic [SHIFT_W-1:0] shift_t;

    function automatic ctl_reg_t ctl_reset();
        ctl_reg_t r;
        r          = '0;
        r.osc_sel  = 1'b1;
        return r;
    endfunction

    function automatic shift_t pick_shift(input logic lp, input logic [CODE_W-1:0] code,
                                          input shift_t lp_shift);
        shift_t s;
        if (lp) s = lp_shift;
        else    s = shift_t'(code);
        return s;
    endfunction

    function automatic logic [REG_W-1:0] pack_read(input ctl_reg_t r, input logic status);
        logic [REG_W-1:0] v;
        v           = '0;
        v[BIT_RSV]  = 1'b0;
        v[BIT_OSC]  = r.osc_sel;
        v[BIT_STAT] = status;
        v[BIT_HALT] = r.halt;
        v[BIT_WEN]  = r.wake_en;
        v[BIT_LP]   = r.lp_en;
        v[CODE_W-1:0] = r.div_code;
        return v;
    endfunction

endpackage

// File: rtl/sysclk_wake.sv
module sysclk_wake #(
    parameter int          WAKE_N    = 9,
    parameter logic [WAKE_N-1:0] WAKE_MASK = '1
) (
    input  logic [WAKE_N-1:0] wake_evt,
    output logic              any_wake
);
    logic [WAKE_N-1:0] qual;

    for (genvar i = 0; i < WAKE_N; i++) begin : g_qual
        assign qual[i] = wake_evt[i] & WAKE_MASK[i];
    end

    assign any_wake = |qual;

endmodule

// File: rtl/sysclk_regs.sv
module sysclk_regs
    import sysclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             any_wake,
    input  logic             ext_wake,
    output ctl_reg_t         ctl
);
    ctl_reg_t ctl_q, ctl_d;
    logic     wen_blocked;
    logic     exit_lp;

    assign wen_blocked = ctl_q.lp_en && any_wake && wr_data[BIT_WEN];
    assign exit_lp     = ctl_q.lp_en && ctl_q.wake_en && any_wake;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d.osc_sel = wr_data[BIT_OSC];
            ctl_d.halt    = wr_data[BIT_HALT];
            ctl_d.lp_en   = wr_data[BIT_LP];
            if (!wen_blocked)  ctl_d.wake_en  = wr_data[BIT_WEN];
            if (!ctl_q.lp_en)  ctl_d.div_code = wr_data[CODE_W-1:0];
        end
        if (exit_lp)  ctl_d.lp_en = 1'b0;
        if (ext_wake) ctl_d.halt  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= ctl_reset();
        else     ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R5
    code_held_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.lp_en |=> $stable(ctl_q.div_code));

    // R6
    wake_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.lp_en && ctl_q.wake_en && any_wake) |=> !ctl_q.lp_en);

    // R7
    wen_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[BIT_WEN] && ctl_q.lp_en && any_wake && !ctl_q.wake_en)
        |=> !ctl_q.wake_en);

    // R8
    halt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ext_wake |=> !ctl_q.halt);

endmodule

// File: rtl/sysclk_div.sv
module sysclk_div
    import sysclk_pkg::*;
#(
    parameter int LP_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lp_en,
    input  logic [CODE_W-1:0] div_code,
    input  logic              halt,
    output logic              clk_en
);
    localparam int CNT_W = LP_SHIFT;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    shift_t           shift_q;
    shift_t           shift_tgt;
    logic             term;

    assign shift_tgt = pick_shift(lp_en, div_code, shift_t'(LP_SHIFT));

    always_comb begin
        last = '0;
        for (int b = 0; b < CNT_W; b++) begin
            if (b < int'(shift_q)) last[b] = 1'b1;
        end
    end

    assign term = (cnt_q == last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else if (term) begin
            cnt_q   <= '0;
            shift_q <= shift_tgt;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign clk_en = term && !halt && !rst;

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last);

    // R10
    ratio_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_q != $past(shift_q)) |-> $past(term));

endmodule

// File: rtl/sysclk_ctl.sv
module sysclk_ctl
    import sysclk_pkg::*;
#(
    parameter int WAKE_N   = 9,
    parameter int LP_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              xtal_ready,
    input  logic [WAKE_N-1:0] wake_evt,
    input  logic              ext_wake,
    output logic              ring_sel_o,
    output logic              stop_o,
    output logic              clk_en
);
    ctl_reg_t ctl;
    logic     any_wake;
    logic     status;

    sysclk_wake #(.WAKE_N(WAKE_N)) u_wake (
        .wake_evt (wake_evt),
        .any_wake (any_wake)
    );

    sysclk_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .any_wake (any_wake),
        .ext_wake (ext_wake),
        .ctl      (ctl)
    );

    sysclk_div #(.LP_SHIFT(LP_SHIFT)) u_div (
        .clk      (clk),
        .rst      (rst),
        .lp_en    (ctl.lp_en),
        .div_code (ctl.div_code),
        .halt     (ctl.halt),
        .clk_en   (clk_en)
    );

    assign status     = ctl.osc_sel | ~xtal_ready;
    assign ring_sel_o = status;
    assign stop_o     = ctl.halt;
    assign rd_data    = pack_read(ctl, status);

    // R9
    halt_gate_chk: assert property (@(posedge clk) disable iff (rst)
        stop_o |-> !clk_en);

    // R2
    xtal_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_data[BIT_OSC] && xtal_ready) |-> !ring_sel_o);

endmodule

// File: tb/sysclk_ctl_bench.sv
module sysclk_ctl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       xtal_ready = 1'b0;
    logic [8:0] wake_evt = '0;
    logic       ext_wake = 1'b0;
    logic       ring_sel_o, stop_o, clk_en;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sysclk_ctl u_sysclk_ctl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .xtal_ready(xtal_ready), .wake_evt(wake_evt), .ext_wake(ext_wake),
        .ring_sel_o(ring_sel_o), .stop_o(stop_o), .clk_en(clk_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse();
        int guard = 0;
        @(negedge clk);
        while (!clk_en && guard < 1000) begin @(negedge clk); guard++; end
    endtask

    task automatic gap(output int n);
        wait_pulse();
        n = 0;
        do begin @(negedge clk); n++; end while (!clk_en && n < 1000);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset value", rd_data, 8'h60);
        chk("R1 stop low after reset", stop_o, 0);
    endtask

    task automatic t_status();
        wr(8'h00);
        chk("R2 status while crystal warming", rd_data, 8'h20);
        chk("R2 ring_sel_o while warming", ring_sel_o, 1);
        xtal_ready = 1'b1;
        @(negedge clk);
        chk("R2 status on crystal", rd_data, 8'h00);
        chk("R2 ring_sel_o on crystal", ring_sel_o, 0);
        wr(8'hA0);
        chk("R1 bit 7 and R2 bit 5 not writable", rd_data, 8'h00);
    endtask

    task automatic t_codes();
        int n;
        for (int c = 0; c < 4; c++) begin
            wr(8'(c));
            gap(n); gap(n);
            chk($sformatf("R3 period for code %0d", c), n, 1 << c);
        end
    endtask

    task automatic t_lowpower();
        int n;
        wr(8'h05);
        gap(n); gap(n);
        chk("R4 low-power period", n, 256);
        wr(8'h07);
        chk("R5 code write ignored in low-power", rd_data, 8'h05);
        wake_evt[0] = 1'b1;
        @(negedge clk);
        wake_evt[0] = 1'b0;
        @(negedge clk);
        chk("R6 no exit without wake enable", rd_data, 8'h05);
    endtask

    task automatic t_wen_block();
        wake_evt[4] = 1'b1;
        wr(8'h0D);
        chk("R7 wake enable write blocked", rd_data, 8'h05);
        wake_evt[4] = 1'b0;
        wr(8'h0D);
        chk("R7 wake enable write accepted", rd_data, 8'h0D);
    endtask

    task automatic t_switchback();
        int n;
        wait_pulse();
        n = 0;
        repeat (10) begin @(negedge clk); n++; end
        wake_evt[8] = 1'b1;
        @(negedge clk); n++;
        wake_evt[8] = 1'b0;
        chk("R6 low-power cleared, code kept", rd_data, 8'h09);
        while (!clk_en && n < 1000) begin @(negedge clk); n++; end
        chk("R10 interval in progress at exit", n, 256);
        gap(n);
        chk("R6 restored period", n, 2);
    endtask

    task automatic t_halt();
        int hits = 0;
        int n;
        wr(8'h19);
        chk("R8 stop_o raised", stop_o, 1);
        chk("R8 code unchanged by halt", rd_data, 8'h19);
        repeat (20) begin @(negedge clk); if (clk_en) hits++; end
        chk("R9 no enable while halted", hits, 0);
        ext_wake = 1'b1;
        @(negedge clk);
        ext_wake = 1'b0;
        chk("R8 halt cleared by ext_wake", stop_o, 0);
        chk("R8 register after wake", rd_data, 8'h09);
        gap(n);
        chk("R9 enable resumes", n, 2);
    endtask

    task automatic t_ratio_change();
        int n;
        wr(8'h03);
        gap(n); gap(n);
        chk("R3 divide-by-8 before change", n, 8);
        wait_pulse();
        n = 0;
        @(negedge clk); n++;
        wr_en = 1'b1; wr_data = 8'h00;
        @(negedge clk); n++;
        wr_en = 1'b0;
        while (!clk_en && n < 1000) begin @(negedge clk); n++; end
        chk("R10 interval finishes at old ratio", n, 8);
        gap(n);
        chk("R10 new ratio afterwards", n, 1);
    endtask

    initial begin
        t_reset();
        t_status();
        t_codes();
        t_lowpower();
        t_wen_block();
        t_switchback();
        t_halt();
        t_ratio_change();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule